// File: doc/BRIEF.md
# Processor mode control register

This block holds the eight-bit mode and status byte of an eight-bit-bus CPU core that stays compatible with an older processor family. The byte selects the core's operating mode and interrupt handling options. It also keeps two sticky exception flags: divide-by-zero and illegal opcode. The decoder writes the byte through a write strobe and reads it back at any time. The rest of the core uses the decoded mode outputs.

Out of reset the core runs in the legacy mode. The mode-selection fields (extended mode, 32-bit mode, floating-point enable) can change only during a configuration window. That window closes for good at the first load of the stack pointer and opens again only on the next reset. The interrupt-option fields stay writable throughout. The 32-bit and floating-point selections count only while extended mode is set.

The asynchronous active-low reset reaches the registers through a small synchronizer, so its release is aligned to the clock.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: While reset is held, and after reset before any write, `mode_value` reads 0x00, `legacy_mode` is 1, and every other output is 0.
- R2: `mode_value` bit positions are: bit 7 divide-by-zero flag, bit 6 illegal-opcode flag, bit 5 FPU select, bit 4 32-bit select, bit 3 auxiliary option, bit 2 extended-interrupt edge select, bit 1 fast-interrupt-as-normal, bit 0 extended mode. A write changes the readable value at the next clock edge.
- R3: Bits 0, 4 and 5 follow writes only while the window is open. From the clock edge that takes the first `sp_load` pulse, writes to those bits are ignored until reset. A write in the same cycle as that first pulse still takes effect.
- R4: `wide_mode` equals bit 4 and `fpu_enable` equals bit 5 only when bit 0 is 1; otherwise both are 0. `legacy_mode` is the inverse of bit 0.
- R5: Bits 1, 2 and 3 follow every write whether or not the window is closed. `firq_as_irq` shows bit 1 and `xirq_edge` shows bit 2 (0 = level-sensitive, 1 = edge-sensitive).
- R6: A `div0_evt` pulse sets bit 7 and an `illop_evt` pulse sets bit 6 at the next edge. Both bits stay set until reset, and writes to them are ignored.
- R7: `lock_active` is 1 for exactly the one cycle after the edge that takes the first `sp_load` pulse since reset. Later pulses do not raise it.
- R8: A new reset clears both flags and reopens the configuration window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| sp_load | input | 1 | Stack pointer loaded pulse |
| div0_evt | input | 1 | Divide-by-zero event pulse |
| illop_evt | input | 1 | Illegal-opcode event pulse |
| mode_value | output | 8 | Readable register value |
| legacy_mode | output | 1 | Legacy mode selected |
| ext_mode | output | 1 | Extended mode selected |
| wide_mode | output | 1 | Effective 32-bit mode |
| fpu_enable | output | 1 | Effective FPU enable |
| firq_as_irq | output | 1 | Fast interrupt handled as normal interrupt |
| xirq_edge | output | 1 | Extended interrupt lines edge-sensitive |
| lock_active | output | 1 | One-cycle pulse when the window closes |

## Verification
The bench uses the default parameters: a two-stage reset synchronizer and two sticky flags. With two stages, the release of reset is internal and spread over several cycles, and the per-cycle reference model has to line up with it. With two flags, the generate loop is built with both an independent flag and a flag that is set together with the other. The bench reaches writes in the same cycle as the first stack load, repeated stack loads, events that coincide with writes, and a reset in the middle of a run after the window has closed.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;
  localparam int MODE_REG_W = 8;
  localparam int LOCK_W     = 3;  // em, w32, fpu
  localparam int FREE_W     = 3;  // fm, ed, aux
  localparam int FLAG_W     = 2;  // il, dz

  typedef struct packed {
    logic dz;
    logic il;
    logic fpu;
    logic w32;
    logic aux;
    logic ed;
    logic fm;
    logic em;
  } mode_reg_t;
endpackage

// File: rtl/mode_rst_sync.sv
module mode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mode_lock_reg.sv
module mode_lock_reg #(
  parameter int LOCK_W = 3,
  parameter int FREE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LOCK_W-1:0] wr_lock_fields,
  input  logic [FREE_W-1:0] wr_free_fields,
  input  logic              sp_load,
  output logic [LOCK_W-1:0] lock_fields,
  output logic [FREE_W-1:0] free_fields,
  output logic              lock_pulse
);
  logic              locked_q, locked_nxt;
  logic              pulse_q, pulse_nxt;
  logic [LOCK_W-1:0] lockf_q, lockf_nxt;
  logic [FREE_W-1:0] freef_q, freef_nxt;
  logic              lockf_en;

  always_comb begin
    lockf_en   = wr_en & ~locked_q;
    lockf_nxt  = lockf_en ? wr_lock_fields : lockf_q;
    freef_nxt  = wr_en ? wr_free_fields : freef_q;
    locked_nxt = locked_q | sp_load;
    pulse_nxt  = sp_load & ~locked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockf_q  <= '0;
      freef_q  <= '0;
      locked_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      lockf_q  <= lockf_nxt;
      freef_q  <= freef_nxt;
      locked_q <= locked_nxt;
      pulse_q  <= pulse_nxt;
    end
  end

  assign lock_fields = lockf_q;
  assign free_fields = freef_q;
  assign lock_pulse  = pulse_q;

  // R3: a closed window holds the mode fields
  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(lockf_q));
  // R7: the pulse lasts one cycle and leaves the window closed
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_pulse_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> locked_q);
  // R5: free fields follow each write
  assert_free_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (freef_q == $past(wr_free_fields)));
endmodule

// File: rtl/mode_sticky_flags.sv
module mode_sticky_flags #(
  parameter int FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_evt,
  output logic [FLAG_W-1:0] flags
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic flag_q, flag_nxt;

    always_comb begin
      flag_nxt = flag_q | set_evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_nxt;
    end

    assign flags[i] = flag_q;

    // R6: set by its event and never cleared without reset
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flag_q);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |=> flag_q);
  end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import cpu_mode_pkg::*;
(
  input  mode_reg_t regv,
  output logic      legacy_mode,
  output logic      ext_mode,
  output logic      wide_mode,
  output logic      fpu_enable,
  output logic      firq_as_irq,
  output logic      xirq_edge
);
  always_comb begin
    ext_mode    = regv.em;
    legacy_mode = ~regv.em;
    wide_mode   = regv.em & regv.w32;
    fpu_enable  = regv.em & regv.fpu;
    firq_as_irq = regv.fm;
    xirq_edge   = regv.ed;
  end
endmodule

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl
  import cpu_mode_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [MODE_REG_W-1:0] wr_data,
  input  logic                  sp_load,
  input  logic                  div0_evt,
  input  logic                  illop_evt,
  output logic [MODE_REG_W-1:0] mode_value,
  output logic                  legacy_mode,
  output logic                  ext_mode,
  output logic                  wide_mode,
  output logic                  fpu_enable,
  output logic                  firq_as_irq,
  output logic                  xirq_edge,
  output logic                  lock_active
);
  logic              rst_n_int;
  mode_reg_t         wr_v, reg_v;
  logic [LOCK_W-1:0] lockf;
  logic [FREE_W-1:0] freef;
  logic [FLAG_W-1:0] flags;

  assign wr_v = mode_reg_t'(wr_data);

  mode_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  mode_lock_reg #(.LOCK_W(LOCK_W), .FREE_W(FREE_W)) u_lock (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en),
    .wr_lock_fields({wr_v.fpu, wr_v.w32, wr_v.em}),
    .wr_free_fields({wr_v.aux, wr_v.ed, wr_v.fm}),
    .sp_load(sp_load),
    .lock_fields(lockf), .free_fields(freef), .lock_pulse(lock_active)
  );

  mode_sticky_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n_int),
    .set_evt({div0_evt, illop_evt}), .flags(flags)
  );

  always_comb begin
    reg_v     = '0;
    reg_v.dz  = flags[1];
    reg_v.il  = flags[0];
    reg_v.fpu = lockf[2];
    reg_v.w32 = lockf[1];
    reg_v.em  = lockf[0];
    reg_v.aux = freef[2];
    reg_v.ed  = freef[1];
    reg_v.fm  = freef[0];
  end

  assign mode_value = reg_v;

  mode_decode u_dec (
    .regv(reg_v), .legacy_mode(legacy_mode), .ext_mode(ext_mode),
    .wide_mode(wide_mode), .fpu_enable(fpu_enable),
    .firq_as_irq(firq_as_irq), .xirq_edge(xirq_edge)
  );

  // R4: outside extended mode the wide and FPU outputs stay low
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    legacy_mode |-> (!wide_mode && !fpu_enable));
  // R6: writes never clear a set flag at the port
  assert_flag_port_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    mode_value[7] |=> mode_value[7]);
endmodule

// File: tb/cpu_mode_ctrl_test.sv
module cpu_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, sp_load, div0_evt, illop_evt;
  logic [7:0] wr_data;
  logic [7:0] mode_value;
  logic       legacy_mode, ext_mode, wide_mode, fpu_enable;
  logic       firq_as_irq, xirq_edge, lock_active;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference model state
  bit m_em, m_w32, m_fpu, m_aux, m_ed, m_fm, m_dz, m_il, m_lock, m_pulse;

  always #10 clk = ~clk;

  cpu_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sp_load(sp_load), .div0_evt(div0_evt), .illop_evt(illop_evt),
    .mode_value(mode_value), .legacy_mode(legacy_mode), .ext_mode(ext_mode),
    .wide_mode(wide_mode), .fpu_enable(fpu_enable), .firq_as_irq(firq_as_irq),
    .xirq_edge(xirq_edge), .lock_active(lock_active)
  );

  task automatic chk(string req, string name, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, name, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_em, m_w32, m_fpu, m_aux, m_ed, m_fm, m_dz, m_il, m_lock, m_pulse} = '0;
  endtask

  task automatic compare_all();
    bit [7:0] ev;
    ev = {m_dz, m_il, m_fpu, m_w32, m_aux, m_ed, m_fm, m_em};
    chk({cur_req, "/R2"}, "mode_value", mode_value, ev);
    chk({cur_req, "/R4"}, "legacy_mode", legacy_mode, !m_em);
    chk({cur_req, "/R4"}, "ext_mode", ext_mode, m_em);
    chk({cur_req, "/R4"}, "wide_mode", wide_mode, m_em & m_w32);
    chk({cur_req, "/R4"}, "fpu_enable", fpu_enable, m_em & m_fpu);
    chk({cur_req, "/R5"}, "firq_as_irq", firq_as_irq, m_fm);
    chk({cur_req, "/R5"}, "xirq_edge", xirq_edge, m_ed);
    chk({cur_req, "/R7"}, "lock_active", lock_active, m_pulse);
  endtask

  // one cycle: drive after the falling edge, update model at the rising edge,
  // compare at the next falling edge
  task automatic step(bit we, bit [7:0] d, bit sp, bit dz, bit il);
    wr_en = we; wr_data = d; sp_load = sp; div0_evt = dz; illop_evt = il;
    @(posedge clk);
    if (we) begin
      if (!m_lock) begin
        m_em = d[0]; m_w32 = d[4]; m_fpu = d[5];
      end
      m_fm = d[1]; m_ed = d[2]; m_aux = d[3];
    end
    if (dz) m_dz = 1'b1;
    if (il) m_il = 1'b1;
    m_pulse = sp && !m_lock;
    if (sp) m_lock = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    cur_req = "R1";
    rst_n = 1'b0;
    wr_en = 0; wr_data = 8'h00; sp_load = 0; div0_evt = 0; illop_evt = 0;
    model_reset();
    repeat (2) @(negedge clk);
    compare_all();  // R1: values during reset
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1", "reset value", mode_value, 8'h00);

    // R2/R6: writing all ones before lock: flags stay clear
    cur_req = "R2";
    step(1, 8'hFF, 0, 0, 0);
    chk("R6", "flags not writable", mode_value[7:6], 2'b00);
    chk("R2", "write readback", mode_value, 8'h3F);

    // R4: 32-bit and FPU set but extended mode off
    cur_req = "R4";
    step(1, 8'h30, 0, 0, 0);
    chk("R4", "wide gated", wide_mode, 0);
    chk("R4", "fpu gated", fpu_enable, 0);
    step(1, 8'h31, 0, 0, 0);
    chk("R4", "wide active", wide_mode, 1);

    // R3/R7: close the window
    cur_req = "R3";
    step(1, 8'h01, 0, 0, 0);
    cur_req = "R7";
    step(0, 8'h00, 1, 0, 0);
    chk("R7", "lock pulse", lock_active, 1);
    step(0, 8'h00, 0, 0, 0);
    chk("R7", "pulse ends", lock_active, 0);
    step(0, 8'h00, 1, 0, 0);
    chk("R7", "no second pulse", lock_active, 0);

    cur_req = "R3";
    step(1, 8'h3E, 0, 0, 0);
    chk("R3", "locked fields ignored", mode_value, 8'h0F);
    cur_req = "R5";
    step(1, 8'h00, 0, 0, 0);
    chk("R5", "free fields writable after lock", mode_value, 8'h01);
    step(1, 8'h04, 0, 0, 0);
    chk("R5", "edge select", xirq_edge, 1);

    // R6: sticky flags
    cur_req = "R6";
    step(0, 8'h00, 0, 1, 0);
    chk("R6", "dz set", mode_value[7], 1);
    step(1, 8'h00, 0, 0, 1);
    chk("R6", "il set, write ignored", mode_value[7:6], 2'b11);
    for (int i = 0; i < 3; i++) step(1, 8'h00, 0, 0, 0);
    chk("R6", "flags held", mode_value[7:6], 2'b11);

    // R8: reset reopens window and clears flags
    do_reset();
    cur_req = "R8";
    chk("R8", "flags cleared", mode_value, 8'h00);
    step(1, 8'h21, 0, 0, 0);
    chk("R8", "window open again", fpu_enable, 1);

    // R3: write in the same cycle as the first stack load takes effect
    cur_req = "R3";
    step(1, 8'h11, 1, 0, 0);
    chk("R3", "same-cycle write", mode_value, 8'h11);
    chk("R7", "pulse after same-cycle load", lock_active, 1);
    step(1, 8'h00, 0, 1, 1);
    chk("R3", "after lock", mode_value, 8'hD1);
    chk("R4", "wide held", wide_mode, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule